// File: doc/BRIEF.md
# Shader Node Instruction Sequencer

This block steps through a fragment program that is split into one to four nodes and produces one instruction address per clock. Each node first issues a run of texture (TEX) instructions and then a run of ALU instructions. The two instruction streams are addressed separately. Each stream has its own base register, and each node carries an offset into each stream. An outer controller loads the configuration, pulses `start`, and reads the tagged address stream until `done`.

The active nodes occupy the highest-numbered descriptor slots. The final node is always in the top slot, and the first node is in slot `NODES-1-last_node`. The lower slots are not used. Before the first instruction is issued, the block checks the configuration against the node rules. A configuration that breaks a rule issues nothing and ends with an error flag.

Top module: `shader_node_seq`

## Requirements
- R1: When `start` is sampled high while the block is idle and the configuration is legal, `busy` and the first `issue_valid` appear in the next cycle. After that, one instruction is issued every cycle with no gaps until the program ends.
- R2: Nodes are walked in ascending slot order. Within each node, every TEX instruction is issued, with `issue_alu`=0, before any of its ALU instructions. The TEX address for index i is `tex_base + tex_off[slot] + i`.
- R3: ALU instructions are tagged `issue_alu`=1, and the address for index i is `alu_base + alu_off[slot] + i`.
- R4: The instruction count of each run is the end field plus one, modulo 2^AW, so an all-ones end field means zero instructions. The first active node may have zero TEX instructions, and in that case it goes directly to its ALU run.
- R5: An active node other than the first one that has zero TEX instructions is an error.
- R6: An active node that has zero ALU instructions is an error.
- R7: The last-node flag (bit s of `cfg_last_flag` belongs to slot s) must be set for slot NODES-1 and must be clear in every other slot, whether that slot is active or not. Any other flag pattern is an error.
- R8: On an error, `done` and `cfg_err` both pulse in the cycle after `start`, and nothing is issued.
- R9: Slots below `NODES-1-last_node` are ignored, apart from their flags (R7). Their offset and end fields do not affect the error result or the issued stream.
- R10: In the cycle after the last ALU instruction of the final node, `done` pulses for one cycle with `cfg_err` low. `busy` is low in the cycle after that.
- R11: A `start` pulse while `busy` is high has no effect on the stream in progress.
- R12: After reset, `busy`, `issue_valid`, `done` and `cfg_err` are all low.
- R13: Address sums wrap modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a program when idle |
| cfg_tex_base | input | AW | TEX stream base address |
| cfg_alu_base | input | AW | ALU stream base address |
| cfg_last_node | input | NIW | Number of nodes minus one |
| cfg_tex_off | input | NODES*AW | Per-slot TEX offset, slot s at bits [s*AW +: AW] |
| cfg_tex_end | input | NODES*AW | Per-slot TEX last index (all-ones = none) |
| cfg_alu_off | input | NODES*AW | Per-slot ALU offset |
| cfg_alu_end | input | NODES*AW | Per-slot ALU last index (all-ones = none) |
| cfg_last_flag | input | NODES | Per-slot last-node flag |
| busy | output | 1 | Program in progress, or done cycle |
| issue_valid | output | 1 | An instruction address is issued this cycle |
| issue_alu | output | 1 | 1 = ALU instruction, 0 = TEX instruction |
| issue_addr | output | AW | Absolute instruction address |
| done | output | 1 | One-cycle end-of-program pulse |
| cfg_err | output | 1 | Qualifies `done`: the configuration was illegal |

## Verification
`start` passes through one register stage. The first issued address, or the `done`/`cfg_err` pair for an illegal configuration, therefore appears in the cycle after the edge that samples `start`. For a legal program of N instructions, instruction k appears k cycles after that first cycle and `done` appears N cycles after it. The bench drives inputs and samples outputs on the falling edge and numbers each sampled cycle from the first one after `start`. It requires issue k to appear in cycle k, `done` to appear in cycle N (or cycle 0 for an error), and `busy` to be low one cycle after `done`.

// File: rtl/snseq_pkg.sv
package snseq_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_TEX  = 2'd1,
    SQ_ALU  = 2'd2,
    SQ_FIN  = 2'd3
  } sq_state_e;
endpackage

// File: rtl/snseq_cfg_check.sv
module snseq_cfg_check #(
  parameter int NODES = 4,
  parameter int AW    = 6,
  parameter int NIW   = 2
) (
  input  logic [NIW-1:0]      last_node,
  input  logic [NODES*AW-1:0] tex_end,
  input  logic [NODES*AW-1:0] alu_end,
  input  logic [NODES-1:0]    last_flag,
  output logic [NODES*AW-1:0] tex_cnt,
  output logic [NODES*AW-1:0] alu_cnt,
  output logic [NIW-1:0]      first_slot,
  output logic                cfg_bad
);
  logic [NODES-1:0] slot_bad;
  logic             range_bad;

  assign first_slot = NIW'(NODES - 1) - last_node;
  assign range_bad  = (int'(last_node) > NODES - 1);

  for (genvar s = 0; s < NODES; s++) begin : g_slot
    logic act;
    logic flag_ok;
    assign tex_cnt[s*AW +: AW] = tex_end[s*AW +: AW] + AW'(1);
    assign alu_cnt[s*AW +: AW] = alu_end[s*AW +: AW] + AW'(1);
    assign act     = (NIW'(s) >= first_slot);
    assign flag_ok = (last_flag[s] == (s == NODES - 1));
    assign slot_bad[s] = !flag_ok
                       || (act && (alu_cnt[s*AW +: AW] == '0))
                       || (act && (NIW'(s) != first_slot) && (tex_cnt[s*AW +: AW] == '0));
  end

  assign cfg_bad = range_bad || (|slot_bad);
endmodule

// File: rtl/snseq_ctrl.sv
module snseq_ctrl
  import snseq_pkg::*;
#(
  parameter int NODES = 4,
  parameter int AW    = 6,
  parameter int NIW   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                cfg_bad,
  input  logic [NIW-1:0]      first_slot,
  input  logic [NODES*AW-1:0] tex_cnt,
  input  logic [NODES*AW-1:0] alu_cnt,
  output sq_state_e           state_o,
  output logic [NIW-1:0]      slot_o,
  output logic [AW-1:0]       idx_o,
  output logic                err_o
);
  sq_state_e      state_q, state_d;
  logic [NIW-1:0] slot_q, slot_d;
  logic [AW-1:0]  idx_q, idx_d;
  logic           err_q, err_d;
  logic           en;
  logic [AW-1:0]  cur_tex, cur_alu, first_tex;
  logic           tex_last, alu_last;

  assign cur_tex   = tex_cnt[slot_q*AW +: AW];
  assign cur_alu   = alu_cnt[slot_q*AW +: AW];
  assign first_tex = tex_cnt[first_slot*AW +: AW];
  assign tex_last  = (idx_q == cur_tex - AW'(1));
  assign alu_last  = (idx_q == cur_alu - AW'(1));
  assign en        = (state_q != SQ_IDLE) || start;

  always_comb begin
    state_d = state_q;
    slot_d  = slot_q;
    idx_d   = idx_q;
    err_d   = err_q;
    case (state_q)
      SQ_IDLE: begin
        err_d  = cfg_bad;
        slot_d = first_slot;
        idx_d  = '0;
        if (cfg_bad)              state_d = SQ_FIN;
        else if (first_tex != '0) state_d = SQ_TEX;
        else                      state_d = SQ_ALU;
      end
      SQ_TEX: begin
        if (tex_last) begin
          idx_d   = '0;
          state_d = SQ_ALU;
        end else begin
          idx_d = idx_q + AW'(1);
        end
      end
      SQ_ALU: begin
        if (alu_last) begin
          idx_d = '0;
          if (slot_q == NIW'(NODES - 1)) begin
            state_d = SQ_FIN;
          end else begin
            slot_d  = slot_q + NIW'(1);
            state_d = SQ_TEX;
          end
        end else begin
          idx_d = idx_q + AW'(1);
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      slot_q  <= '0;
      idx_q   <= '0;
      err_q   <= 1'b0;
    end else if (en) begin
      state_q <= state_d;
      slot_q  <= slot_d;
      idx_q   <= idx_d;
      err_q   <= err_d;
    end
  end

  assign state_o = state_q;
  assign slot_o  = slot_q;
  assign idx_o   = idx_q;
  assign err_o   = err_q;

  p_start_from_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && start) |=> (state_q != SQ_IDLE));
  p_bad_cfg_to_fin_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_IDLE && start && cfg_bad) |=> (state_q == SQ_FIN && err_q));
  p_fin_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_FIN) |=> (state_q == SQ_IDLE));
  p_busy_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == SQ_TEX || state_q == SQ_ALU) && start) |=> (state_q != SQ_IDLE));
endmodule

// File: rtl/snseq_addr_gen.sv
module snseq_addr_gen #(
  parameter int NODES = 4,
  parameter int AW    = 6,
  parameter int NIW   = 2
) (
  input  logic [AW-1:0]       tex_base,
  input  logic [AW-1:0]       alu_base,
  input  logic [NODES*AW-1:0] tex_off,
  input  logic [NODES*AW-1:0] alu_off,
  input  logic [NIW-1:0]      slot,
  input  logic [AW-1:0]       idx,
  input  logic                sel_alu,
  output logic [AW-1:0]       addr
);
  logic [AW-1:0] base, off;

  always_comb begin
    if (sel_alu) begin
      base = alu_base;
      off  = alu_off[slot*AW +: AW];
    end else begin
      base = tex_base;
      off  = tex_off[slot*AW +: AW];
    end
  end

  assign addr = base + off + idx;
endmodule

// File: rtl/shader_node_seq.sv
module shader_node_seq
  import snseq_pkg::*;
#(
  parameter int NODES = 4,
  parameter int AW    = 6,
  localparam int NIW  = (NODES > 1) ? $clog2(NODES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [AW-1:0]       cfg_tex_base,
  input  logic [AW-1:0]       cfg_alu_base,
  input  logic [NIW-1:0]      cfg_last_node,
  input  logic [NODES*AW-1:0] cfg_tex_off,
  input  logic [NODES*AW-1:0] cfg_tex_end,
  input  logic [NODES*AW-1:0] cfg_alu_off,
  input  logic [NODES*AW-1:0] cfg_alu_end,
  input  logic [NODES-1:0]    cfg_last_flag,
  output logic                busy,
  output logic                issue_valid,
  output logic                issue_alu,
  output logic [AW-1:0]       issue_addr,
  output logic                done,
  output logic                cfg_err
);
  logic [NODES*AW-1:0] tex_cnt, alu_cnt;
  logic [NIW-1:0]      first_slot, slot;
  logic [AW-1:0]       idx;
  logic                cfg_bad, err_q;
  sq_state_e           state;

  snseq_cfg_check #(.NODES(NODES), .AW(AW), .NIW(NIW)) u_check (
    .last_node (cfg_last_node),
    .tex_end   (cfg_tex_end),
    .alu_end   (cfg_alu_end),
    .last_flag (cfg_last_flag),
    .tex_cnt   (tex_cnt),
    .alu_cnt   (alu_cnt),
    .first_slot(first_slot),
    .cfg_bad   (cfg_bad)
  );

  snseq_ctrl #(.NODES(NODES), .AW(AW), .NIW(NIW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cfg_bad   (cfg_bad),
    .first_slot(first_slot),
    .tex_cnt   (tex_cnt),
    .alu_cnt   (alu_cnt),
    .state_o   (state),
    .slot_o    (slot),
    .idx_o     (idx),
    .err_o     (err_q)
  );

  snseq_addr_gen #(.NODES(NODES), .AW(AW), .NIW(NIW)) u_addr (
    .tex_base(cfg_tex_base),
    .alu_base(cfg_alu_base),
    .tex_off (cfg_tex_off),
    .alu_off (cfg_alu_off),
    .slot    (slot),
    .idx     (idx),
    .sel_alu (state == SQ_ALU),
    .addr    (issue_addr)
  );

  assign busy        = (state != SQ_IDLE);
  assign issue_valid = (state == SQ_TEX) || (state == SQ_ALU);
  assign issue_alu   = (state == SQ_ALU);
  assign done        = (state == SQ_FIN);
  assign cfg_err     = done && err_q;

  p_tex_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && !issue_alu && $past(issue_valid && !issue_alu))
      |-> (issue_addr == AW'($past(issue_addr) + AW'(1))));
  p_alu_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_valid && issue_alu && $past(issue_valid && issue_alu))
      |-> (issue_addr == AW'($past(issue_addr) + AW'(1))));
  p_err_no_issue_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> (done && !issue_valid));
endmodule

// File: tb/test_shader_node_seq.sv
module test_shader_node_seq;
  localparam int NODES = 4;
  localparam int AW    = 6;
  localparam int MODV  = 64;
  localparam time CLK_P = 4ns;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] cfg_tex_base = '0, cfg_alu_base = '0;
  logic [1:0] cfg_last_node = '0;
  logic [NODES*AW-1:0] cfg_tex_off = '0, cfg_tex_end = '0, cfg_alu_off = '0, cfg_alu_end = '0;
  logic [NODES-1:0] cfg_last_flag = '0;
  logic busy, issue_valid, issue_alu, done, cfg_err;
  logic [AW-1:0] issue_addr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  int toff[4], tend[4], aoff[4], aend[4];
  bit flg[4];
  int last, tb, ab;
  bit exp_err;
  int exp_addr[$];
  bit exp_alu[$];

  always #(CLK_P/2) clk = ~clk;

  shader_node_seq #(.NODES(NODES), .AW(AW)) i_shader_node_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_tex_base(cfg_tex_base), .cfg_alu_base(cfg_alu_base),
    .cfg_last_node(cfg_last_node),
    .cfg_tex_off(cfg_tex_off), .cfg_tex_end(cfg_tex_end),
    .cfg_alu_off(cfg_alu_off), .cfg_alu_end(cfg_alu_end),
    .cfg_last_flag(cfg_last_flag),
    .busy(busy), .issue_valid(issue_valid), .issue_alu(issue_alu),
    .issue_addr(issue_addr), .done(done), .cfg_err(cfg_err)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic legal_base();
    last = 3; tb = 0; ab = 0;
    for (int s = 0; s < 4; s++) begin
      toff[s] = 0; tend[s] = 0; aoff[s] = 0; aend[s] = 0; flg[s] = (s == 3);
    end
  endtask

  task automatic apply_cfg();
    cfg_tex_base  = AW'(tb);
    cfg_alu_base  = AW'(ab);
    cfg_last_node = 2'(last);
    for (int s = 0; s < 4; s++) begin
      cfg_tex_off[s*AW +: AW] = AW'(toff[s]);
      cfg_tex_end[s*AW +: AW] = AW'(tend[s]);
      cfg_alu_off[s*AW +: AW] = AW'(aoff[s]);
      cfg_alu_end[s*AW +: AW] = AW'(aend[s]);
      cfg_last_flag[s]        = flg[s];
    end
  endtask

  // Expected stream from the node rules: counts = end+1 mod 64, slots 3-last..3
  task automatic build_expected();
    int first;
    first = 3 - last;
    exp_err = 0;
    exp_addr.delete();
    exp_alu.delete();
    for (int s = 0; s < 4; s++)
      if (flg[s] != (s == 3)) exp_err = 1;
    for (int s = first; s < 4; s++) begin
      if (s != first && ((tend[s] + 1) % MODV) == 0) exp_err = 1;
      if (((aend[s] + 1) % MODV) == 0) exp_err = 1;
    end
    if (!exp_err) begin
      for (int s = first; s < 4; s++) begin
        for (int i = 0; i < (tend[s] + 1) % MODV; i++) begin
          exp_addr.push_back((tb + toff[s] + i) % MODV);
          exp_alu.push_back(1'b0);
        end
        for (int i = 0; i < (aend[s] + 1) % MODV; i++) begin
          exp_addr.push_back((ab + aoff[s] + i) % MODV);
          exp_alu.push_back(1'b1);
        end
      end
    end
  endtask

  task automatic run_prog(input string tag, input int glitch_cyc);
    int got_addr[$];
    bit got_alu[$];
    int got_cyc[$];
    int done_cyc;
    bit err_seen;
    int n;
    apply_cfg();
    build_expected();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    done_cyc = -1;
    err_seen = 0;
    for (int cyc = 0; cyc < 400; cyc++) begin
      start = (cyc == glitch_cyc);
      if (issue_valid) begin
        got_addr.push_back(int'(issue_addr));
        got_alu.push_back(issue_alu);
        got_cyc.push_back(cyc);
      end
      if (done) begin
        done_cyc = cyc;
        err_seen = cfg_err;
        break;
      end
      @(negedge clk);
    end
    start = 1'b0;
    n = exp_addr.size();
    chk(err_seen == exp_err, tag, "cfg_err at done", int'(err_seen), int'(exp_err));
    if (exp_err) begin
      chk(got_addr.size() == 0, "R8", "issues on error", got_addr.size(), 0);
      chk(done_cyc == 0, "R8", "done cycle on error", done_cyc, 0);
    end else begin
      chk(done_cyc == n, "R10", "done cycle", done_cyc, n);
      chk(got_addr.size() == n, tag, "issue count", got_addr.size(), n);
      if (n > 0 && got_cyc.size() > 0)
        chk(got_cyc[0] == 0, "R1", "first issue cycle", got_cyc[0], 0);
      for (int i = 0; i < n && i < got_addr.size(); i++) begin
        chk(got_alu[i] == exp_alu[i], "R2", "issue kind", int'(got_alu[i]), int'(exp_alu[i]));
        chk(got_addr[i] == exp_addr[i], exp_alu[i] ? "R3" : "R2", "issue addr",
            got_addr[i], exp_addr[i]);
        chk(got_cyc[i] == i, "R1", "issue cycle", got_cyc[i], i);
      end
    end
    @(negedge clk);
    chk(!busy && !done, "R10", "idle after done", int'(busy), 0);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    chk(!busy && !issue_valid && !done && !cfg_err, "R12", "outputs in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !issue_valid && !done && !cfg_err, "R12", "outputs after reset", int'(issue_valid), 0);

    // single node
    legal_base(); last = 0; tend[3] = 1; aend[3] = 2; toff[3] = 5; aoff[3] = 9; tb = 3; ab = 20;
    run_prog("R1", -1);
    // four nodes, first has zero TEX
    legal_base(); tend[0] = 63; aend[0] = 1; tend[1] = 2; aend[1] = 0; toff[2] = 7; tend[2] = 0;
    aoff[3] = 30; aend[3] = 3; ab = 4; tb = 11;
    run_prog("R4", -1);
    // two nodes, junk in inactive slots
    legal_base(); last = 1; tend[0] = 63; aend[0] = 63; aend[1] = 63; toff[1] = 40;
    tend[2] = 1; aend[2] = 1; tend[3] = 0; aend[3] = 2; aoff[3] = 17;
    run_prog("R9", -1);
    // later node zero TEX
    legal_base(); last = 2; tend[2] = 63;
    run_prog("R5", -1);
    // active node zero ALU
    legal_base(); last = 1; aend[3] = 63;
    run_prog("R6", -1);
    // extra flag in an inactive slot
    legal_base(); last = 0; flg[1] = 1;
    run_prog("R7", -1);
    // missing flag in top slot
    legal_base(); flg[3] = 0; flg[2] = 1;
    run_prog("R7", -1);
    // address wrap
    legal_base(); last = 0; tb = 60; toff[3] = 2; tend[3] = 5; ab = 63; aoff[3] = 63; aend[3] = 3;
    run_prog("R13", -1);
    // start while busy
    legal_base(); tend[1] = 3; aend[2] = 2;
    run_prog("R11", 1);
    legal_base(); last = 0; tend[3] = 2; aend[3] = 1;
    run_prog("R11", 3);

    for (int r = 0; r < 40; r++) begin
      last = $urandom_range(0, 3);
      tb = $urandom_range(0, 63);
      ab = $urandom_range(0, 63);
      for (int s = 0; s < 4; s++) begin
        toff[s] = $urandom_range(0, 63);
        aoff[s] = $urandom_range(0, 63);
        tend[s] = ($urandom_range(0, 9) == 0) ? 63 : $urandom_range(0, 3);
        aend[s] = ($urandom_range(0, 11) == 0) ? 63 : $urandom_range(0, 4);
        flg[s]  = (s == 3);
      end
      if ($urandom_range(0, 9) == 0) begin
        int k;
        k = $urandom_range(0, 3);
        flg[k] = !flg[k];
      end
      run_prog("R2", ($urandom_range(0, 3) == 0) ? 1 : -1);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule